// File: doc/BRIEF.md
# Serial Uppercase Character Match Counter

This block takes a character stream one bit per clock and counts how often a chosen target character appears in it. A start pulse sets the character framing. From the cycle after the pulse, each group of eight consecutive bits is gathered into a character, most significant bit first. When the eighth bit arrives, the gathered character is compared with the target. Each equal character adds one to the count.

Only uppercase letters are counted. When the target lies outside the code range 65 to 90 inclusive, no character ever adds to the count. The count is 5 bits wide and holds at 31 rather than rolling over.

Matching is tied to the frame. A bit pattern that straddles a frame edge never counts. A new start pulse clears the count and starts a fresh frame, and any character that was only partly received is dropped.

Top module: `serial_char_counter`

## Requirements
- R1: While `rst_n` is low and after its release, `count` reads 0, and the block waits for a start pulse.
- R2: A cycle with `start` high carries no data bit. The first data bit is sampled on the rising edge after the start cycle. Each following rising edge samples one more bit, and the first bit of a character is its bit 7 (MSB first).
- R3: On the rising edge that samples the eighth bit of a frame, `count` rises by one if the assembled character equals `target`. The new value is visible right after that edge, and `count` changes on no other data edge.
- R4: If `target` is below 65 or above 90, `count` never increases. Both ends of the range, 65 and 90, do count.
- R5: A copy of the target that is not aligned to a frame boundary set by the last start pulse never increases `count`.
- R6: A cycle with `start` high sets `count` to 0 on that edge and resets the bit position. Bits of a partly received character are discarded.
- R7: When `count` is 31, further matches leave it at 31.
- R8: Bits that arrive after reset and before the first start pulse do not change `count`, even if they form the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start and count clear |
| bit_in | input | 1 | Serial data bit, one per clock |
| target | input | 8 | Character code to count |
| count | output | 5 | Number of matching characters since the last start |

## Verification
The hardest case to reach is a restart in the middle of a character that holds a partial copy of the target. If the dropped bits leaked into the next frame, the count would go up one frame too early or on the wrong character. Directed sequences send four bits of the target, then a new start, then a whole target character. Other sequences shift a target copy off its frame by one bit. The random phase adds starts at random bit positions and mixes copies of the target with random characters, and a bench model tracks the frame position bit by bit.

// File: rtl/scc_pkg.sv
package scc_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   typedef enum logic {
      OVF_SATURATE = 1'b0,
      OVF_WRAP     = 1'b1
   } ovf_mode_e;

   // Inclusive code range test, written for any character width.
   function automatic logic code_in_range(input logic [31:0] code,
                                          input int unsigned lo,
                                          input int unsigned hi);
      return (code >= lo) && (code <= hi);
   endfunction

endpackage

// File: rtl/scc_frame_ctr.sv
// Tracks the bit position inside the current character frame.
module scc_frame_ctr #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic shift_en,
   output logic char_done
);
   localparam int unsigned POS_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHAR_W - 1);

   logic [POS_W-1:0] pos_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         armed_q <= 1'b0;
      end else if (start) begin
         pos_q   <= '0;
         armed_q <= 1'b1;
      end else if (armed_q) begin
         if (pos_q == POS_LAST) pos_q <= '0;
         else                   pos_q <= pos_q + 1'b1;
      end
   end

   assign shift_en  = armed_q && !start;
   assign char_done = shift_en && (pos_q == POS_LAST);

endmodule

// File: rtl/scc_shift_reg.sv
// Assembles a character from serial bits; bit order is a parameter.
module scc_shift_reg #(
   parameter int unsigned        CHAR_W = 8,
   parameter scc_pkg::bit_order_e ORDER = scc_pkg::ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [CHAR_W-1:0] char_next
);
   logic [CHAR_W-1:0] sh_q;

   generate
      if (ORDER == scc_pkg::ORDER_MSB_FIRST) begin : g_msb
         assign char_next = {sh_q[CHAR_W-2:0], bit_in};
      end else begin : g_lsb
         assign char_next = {bit_in, sh_q[CHAR_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (shift_en) sh_q <= char_next;
   end

endmodule

// File: rtl/scc_match_cnt.sv
// Match counter with selectable overflow behaviour.
module scc_match_cnt #(
   parameter int unsigned       CNT_W = 5,
   parameter scc_pkg::ovf_mode_e OVF  = scc_pkg::OVF_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             step_ok;

   generate
      if (OVF == scc_pkg::OVF_SATURATE) begin : g_sat
         assign step_ok = (cnt_q != CNT_MAX);
      end else begin : g_wrap
         assign step_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr)              cnt_q <= '0;
      else if (inc && step_ok)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/serial_char_counter.sv
// Counts frame-aligned serial characters equal to an in-range target.
module serial_char_counter #(
   parameter int unsigned        CHAR_W   = 8,
   parameter int unsigned        CNT_W    = 5,
   parameter int unsigned        RANGE_LO = 65,
   parameter int unsigned        RANGE_HI = 90,
   parameter scc_pkg::bit_order_e ORDER   = scc_pkg::ORDER_MSB_FIRST,
   parameter scc_pkg::ovf_mode_e  OVF     = scc_pkg::OVF_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bit_in,
   input  logic [CHAR_W-1:0] target,
   output logic [CNT_W-1:0]  count
);
   generate
      if (CHAR_W < 2 || CHAR_W > 32) begin : g_bad_char_w
         $error("serial_char_counter: CHAR_W must lie in 2..32");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("serial_char_counter: CNT_W must be at least 1");
      end
      if (RANGE_LO > RANGE_HI) begin : g_bad_range
         $error("serial_char_counter: RANGE_LO above RANGE_HI");
      end
   endgenerate

   logic              shift_en;
   logic              char_done;
   logic [CHAR_W-1:0] char_next;
   logic              target_ok;
   logic              hit;

   scc_frame_ctr #(.CHAR_W(CHAR_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .shift_en  (shift_en),
      .char_done (char_done)
   );

   scc_shift_reg #(.CHAR_W(CHAR_W), .ORDER(ORDER)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .bit_in    (bit_in),
      .char_next (char_next)
   );

   assign target_ok = scc_pkg::code_in_range(32'(target), RANGE_LO, RANGE_HI);
   assign hit       = char_done && target_ok && (char_next == target);

   scc_match_cnt #(.CNT_W(CNT_W), .OVF(OVF)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .inc   (hit),
      .cnt   (count)
   );

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
   parameter int unsigned        CHAR_W   = 8,
   parameter int unsigned        CNT_W    = 5,
   parameter int unsigned        RANGE_LO = 65,
   parameter int unsigned        RANGE_HI = 90,
   parameter scc_pkg::ovf_mode_e  OVF     = scc_pkg::OVF_SATURATE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CHAR_W-1:0] target,
   input logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   int unsigned ph;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= 0;
         seen <= 1'b0;
      end else if (start) begin
         ph   <= 0;
         seen <= 1'b1;
      end else if (seen) begin
         ph <= (ph == CHAR_W - 1) ? 0 : ph + 1;
      end
   end

   // R6
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count == '0));

   // R3
   boundary_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && count != '0 && count != $past(count)) |->
         ($past(seen) && $past(ph) == CHAR_W - 1));

   // R4
   off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !scc_pkg::code_in_range(32'(target), RANGE_LO, RANGE_HI))
         |=> (count == '0 || $stable(count) || $past(start)));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (count == '0));

   generate
      if (OVF == scc_pkg::OVF_SATURATE) begin : g_sat_chk
         // R7
         hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (count == CNT_TOP && !start) |=> (count == CNT_TOP));
      end
   endgenerate

endmodule

bind serial_char_counter scc_checker #(
   .CHAR_W(CHAR_W), .CNT_W(CNT_W), .RANGE_LO(RANGE_LO),
   .RANGE_HI(RANGE_HI), .OVF(OVF)
) u_scc_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .target (target),
   .count  (count)
);

// File: tb/test_serial_char_counter.sv
`timescale 1ns/1ps
module test_serial_char_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] target = 8'd65;
   logic [4:0] count;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   // bench model state
   bit       m_armed;
   int       m_pos;
   bit [7:0] m_sh;
   int       m_cnt;

   always #2.5 clk = ~clk;

   serial_char_counter i_serial_char_counter (
      .clk(clk), .rst_n(rst_n), .start(start), .bit_in(bit_in),
      .target(target), .count(count)
   );

   function automatic bit is_upper(input bit [7:0] c);
      return (c >= 8'd65) && (c <= 8'd90);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s count=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare after edge
   task automatic step(input bit st, input bit b, input string req);
      @(negedge clk);
      start  = st;
      bit_in = b;
      @(posedge clk);
      if (st) begin
         m_armed = 1'b1; m_pos = 0; m_cnt = 0;
      end else if (m_armed) begin
         m_sh = {m_sh[6:0], b};
         if (m_pos == 7) begin
            if (is_upper(target) && m_sh == target && m_cnt < 31) m_cnt++;
            m_pos = 0;
         end else m_pos++;
      end
      #1;
      check(count == 5'(m_cnt), req, int'(count), m_cnt);
   endtask

   task automatic send_char(input bit [7:0] c, input string req);
      for (int i = 7; i >= 0; i--) step(1'b0, c[i], req);
   endtask

   task automatic expect_cnt(input int exp, input string req);
      check(count == 5'(exp), req, int'(count), exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20031031));
      m_armed = 0; m_pos = 0; m_sh = 0; m_cnt = 0;
      #12;
      expect_cnt(0, "R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      #1 expect_cnt(0, "R1 after reset");

      // R8: target copies before any start
      target = 8'd65;
      send_char(8'h41, "R8"); send_char(8'h41, "R8");
      expect_cnt(0, "R8");

      // R2/R3: two aligned copies, start-cycle bit is not data
      step(1'b1, 1'b1, "R6");
      send_char(8'h41, "R3");
      expect_cnt(1, "R3 first char");
      send_char(8'h41, "R3");
      expect_cnt(2, "R3 second char");
      send_char(8'h00, "R2");
      expect_cnt(2, "R2 non-match");

      // R6: start clears the count
      step(1'b1, 1'b0, "R6");
      expect_cnt(0, "R6 clear");

      // R4: non-letter targets and range edges
      target = 8'd128;
      send_char(8'h80, "R4"); send_char(8'h80, "R4");
      expect_cnt(0, "R4 code 128");
      target = 8'd64;
      send_char(8'd64, "R4");
      expect_cnt(0, "R4 code 64");
      target = 8'd91;
      send_char(8'd91, "R4");
      expect_cnt(0, "R4 code 91");
      target = 8'd90;
      send_char(8'd90, "R4");
      expect_cnt(1, "R4 code 90");

      // R5: copies offset by one bit
      target = 8'd65;
      step(1'b1, 1'b0, "R6");
      step(1'b0, 1'b0, "R5");
      send_char(8'h41, "R5"); send_char(8'h41, "R5");
      for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R5");
      expect_cnt(0, "R5 offset");

      // R6: restart in the middle of a partial target copy
      step(1'b1, 1'b0, "R6");
      for (int i = 7; i >= 4; i--) step(1'b0, 8'h41 >> i, "R6");
      step(1'b1, 1'b0, "R6");
      send_char(8'h41, "R6");
      expect_cnt(1, "R6 mid restart");

      // R7: saturation
      step(1'b1, 1'b0, "R6");
      for (int i = 0; i < 35; i++) send_char(8'h41, "R7");
      expect_cnt(31, "R7 hold");

      // random phase
      for (int n = 0; n < 600; n++) begin
         int sel;
         bit [7:0] c;
         sel = int'($urandom % 32);
         if (sel == 0) begin
            case ($urandom % 4)
               0: target = 8'd65;
               1: target = 8'd90;
               2: target = 8'(65 + $urandom % 26);
               default: target = 8'($urandom);
            endcase
         end
         if (sel == 1) step(1'b1, 1'($urandom), "R6");
         if (sel == 2) begin
            for (int k = 0; k < int'(1 + $urandom % 7); k++) step(1'b0, 1'($urandom), "R5");
         end
         c = ($urandom % 2 == 0) ? target : 8'($urandom);
         send_char(c, "R3");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule